// File: doc/BRIEF.md
# Filtered Input Change-of-State Detector

This block is a small general-purpose input port. The CPU reads the raw levels of seven input pins at one register address. The value is combinational and is not held in a latch. Four of those pins, bits 0 to 3, also feed change-of-state detectors. Each detector looks at its pin only on a slow sample strobe. It accepts a new level only when two strobes in a row both show that level. A short glitch that lasts for only one strobe is rejected, so the shortest pulse that can be accepted is between one and two strobe periods long.

Each accepted transition, rising or falling, sets a sticky delta flag. The change register shows the four filtered levels next to the four delta flags. Reading that register clears all the flags. If a new change is accepted in the same cycle as the clearing read, its flag is kept. When the enable input is high, the OR of the flags drives an interrupt line. The sample strobe comes from outside the block.

Each detector is a small state machine with three states:
- FLT_INIT: no sample has been taken since reset.
- FLT_STABLE: the filtered level is settled.
- FLT_PEND: one strobe has shown a level that differs from the filtered level.

On each strobe the detector moves as follows:
- load: FLT_INIT goes to FLT_STABLE. The filtered level is taken from the sample, and no flag is set.
- suspect: FLT_STABLE goes to FLT_PEND when the sample differs from the filtered level.
- reject: FLT_PEND goes back to FLT_STABLE when the sample matches the filtered level again.
- accept: FLT_PEND goes to FLT_STABLE when the sample still differs. The filtered level flips and a change pulse is sent to the flag register.

When the strobe is low, the state does not change.

Top module: `input_cos_port`

## Requirements
- R1: When read-enable is high with address 0xD, read data is {1'b1, pins[6:0]} in the same cycle. A high pin reads as 1 and a low pin reads as 0, and bit 7 is always 1.
- R2: When read-enable is high with address 0x4, read data is {filtered levels[3:0], delta flags[3:0]}. The filtered levels are in bits 7:4 and the delta flags in bits 3:0, with bit n matching pin n.
- R3: After reset the levels and flags read as 0. The first strobe loads the filtered levels from the pins and sets no flag.
- R4: A change on pins 0 to 3 is accepted only at the second of two consecutive strobes that both show the new level. The level bit and the delta bit are updated at that clock edge. Pin changes with no strobe have no effect.
- R5: A level that differs for only one strobe and returns at the next strobe is rejected. No flag is set and the filtered level is unchanged.
- R6: Rising and falling transitions both set the flag. Several pins may be accepted at the same strobe.
- R7: Delta flags stay set across further strobes. They clear at the clock edge that ends a read of address 0x4.
- R8: If a change is accepted at the same edge as a clearing read, that flag is set after the edge.
- R9: irq_o equals irq_en_i AND (OR of the four delta flags).
- R10: Pins 4 to 6 are read-only. Their transitions set no flag and change no filtered level.
- R11: Read data is 0 when read-enable is low or the address is neither 0x4 nor 0xD. Reads at other addresses do not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| pins_i | input | 7 | Input pins, already synchronous to clk |
| sample_stb_i | input | 1 | One-cycle sample strobe |
| rd_en_i | input | 1 | CPU read enable |
| rd_addr_i | input | 4 | CPU read address |
| irq_en_i | input | 1 | Interrupt enable |
| rd_data_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the pins are already synchronous to clk. They also assume that a strobe is a single-cycle pulse and that a read is a single-cycle pulse that the CPU issues once per access. The stimulus changes pins, strobe and read controls just after a rising edge and holds each strobe and each read for exactly one cycle. It also produces a clearing read that coincides with an accepting strobe, which is the one case where the set and clear paths meet.

// File: rtl/cosp_pkg.sv
package cosp_pkg;
    typedef enum logic [1:0] {
        FLT_INIT   = 2'd0,
        FLT_STABLE = 2'd1,
        FLT_PEND   = 2'd2
    } flt_state_t;
endpackage

// File: rtl/cos_filter.sv
module cos_filter
    import cosp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic pin_i,
    output logic level_o,
    output logic chg_o
);
    flt_state_t state_q, state_d;
    logic       level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_INIT;
            level_o <= 1'b0;
        end else begin
            state_q <= state_d;
            level_o <= level_d;
        end
    end

    always_comb begin
        state_d = state_q;
        level_d = level_o;
        chg_o   = 1'b0;
        if (stb_i) begin
            unique case (state_q)
                FLT_INIT: begin
                    state_d = FLT_STABLE;
                    level_d = pin_i;
                end
                FLT_STABLE: begin
                    if (pin_i != level_o) state_d = FLT_PEND;
                end
                FLT_PEND: begin
                    state_d = FLT_STABLE;
                    if (pin_i != level_o) begin
                        level_d = pin_i;
                        chg_o   = 1'b1;
                    end
                end
                default: state_d = FLT_INIT;
            endcase
        end
    end

    assert_hold_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(level_o));
    assert_accept_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> (level_o != $past(level_o)));
    assert_glitch_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && state_q == FLT_PEND && pin_i == level_o) |=> ($stable(level_o) && state_q == FLT_STABLE));
    assert_init_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_INIT) |-> !chg_o);
endmodule

// File: rtl/cos_flags.sv
module cos_flags #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flags_o <= '0;
        else if (clr_i) flags_o <= set_i;
        else            flags_o <= flags_o | set_i;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
    assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (flags_o == '0));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/input_cos_port.sv
module input_cos_port #(
    parameter int          PIN_W     = 7,
    parameter int          COS_W     = 4,
    parameter int          ADDR_W    = 4,
    parameter logic [3:0]  PORT_ADDR = 4'hD,
    parameter logic [3:0]  CHG_ADDR  = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pins_i,
    input  logic              sample_stb_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              irq_en_i,
    output logic [PIN_W:0]    rd_data_o,
    output logic              irq_o
);
    localparam int DATA_W = PIN_W + 1;

    logic [COS_W-1:0] levels;
    logic [COS_W-1:0] chg;
    logic [COS_W-1:0] flags;
    logic             port_sel;
    logic             chg_sel;

    assign port_sel = rd_en_i && (rd_addr_i == ADDR_W'(PORT_ADDR));
    assign chg_sel  = rd_en_i && (rd_addr_i == ADDR_W'(CHG_ADDR));

    for (genvar i = 0; i < COS_W; i++) begin : g_det
        cos_filter u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb_i   (sample_stb_i),
            .pin_i   (pins_i[i]),
            .level_o (levels[i]),
            .chg_o   (chg[i])
        );
    end

    cos_flags #(.W(COS_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (chg),
        .clr_i   (chg_sel),
        .flags_o (flags)
    );

    always_comb begin
        rd_data_o = '0;
        if (port_sel)     rd_data_o = {1'b1, pins_i};
        else if (chg_sel) rd_data_o = DATA_W'({levels, flags});
    end

    assign irq_o = irq_en_i && (|flags);

    assert_port_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        port_sel |-> rd_data_o[PIN_W]);
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> (rd_data_o == '0));
endmodule

// File: tb/input_cos_port_test.sv
module input_cos_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pins = 7'h00;
    logic       stb = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    localparam logic [3:0] A_PORT = 4'hD;
    localparam logic [3:0] A_CHG  = 4'h4;

    always #2 clk = ~clk;

    input_cos_port uut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .sample_stb_i(stb),
        .rd_en_i(rd_en), .rd_addr_i(addr), .irq_en_i(irq_en),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    // monitor: pops an expected read value per active read cycle
    always @(negedge clk) begin
        if (rd_en) begin
            logic [7:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read actual=%02h expected=none (R11)", rd_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s read actual=%02h expected=%02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic check(input string t, input logic [7:0] act, input logic [7:0] e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", t, act, e);
        end
    endtask

    task automatic strobe();
        @(posedge clk); #1 stb = 1'b1;
        @(posedge clk); #1 stb = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1 rd_en = 1'b0; addr = 4'h0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog all-R actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R3 reset irq", {7'h0, irq}, 8'h00);
        check("R11 idle data", rd_data, 8'h00);
        rst_n = 1'b1;
        pins = 7'h05;
        rd(A_CHG, 8'h00, "R3 before first strobe");
        strobe();
        rd(A_CHG, 8'h50, "R3 first strobe loads, no flag");
        rd(A_PORT, 8'h85, "R1 raw port");
        rd(4'h0, 8'h00, "R11 other address");
        // R4: no strobe, no effect
        pins = 7'h0D;
        repeat (5) @(posedge clk);
        rd(A_CHG, 8'h50, "R4 no strobe");
        strobe();
        rd(A_CHG, 8'h50, "R4 one sample pending");
        strobe();
        #1 check("R9 irq disabled", {7'h0, irq}, 8'h00);
        irq_en = 1'b1;
        #1 check("R9 irq enabled", {7'h0, irq}, 8'h01);
        rd(A_CHG, 8'hD8, "R4 accepted rise");
        rd(A_CHG, 8'hD0, "R7 cleared by read");
        #1 check("R9 irq after clear", {7'h0, irq}, 8'h00);
        // R5 glitch on bit 0
        pins = 7'h0C; strobe();
        pins = 7'h0D; strobe(); strobe();
        rd(A_CHG, 8'hD0, "R5 glitch rejected");
        // R6 falling edge, R7 sticky, R11 no clear
        pins = 7'h09; strobe(); strobe();
        strobe(); strobe();
        rd(4'h0, 8'h00, "R11 other address no clear");
        rd(A_CHG, 8'h94, "R6 fall flagged, R7 sticky");
        rd(A_CHG, 8'h90, "R7 cleared");
        // R10 upper pins
        pins = 7'h79; strobe(); strobe();
        rd(A_CHG, 8'h90, "R10 upper pins no flag");
        rd(A_PORT, 8'hF9, "R1 raw upper pins");
        // R8 set during clearing read
        pins = 7'h7B; strobe();
        @(posedge clk); #1;
        exp_q.push_back(8'h90); tag_q.push_back("R8 read during accept");
        stb = 1'b1; rd_en = 1'b1; addr = A_CHG;
        @(posedge clk); #1 stb = 1'b0; rd_en = 1'b0; addr = 4'h0;
        rd(A_CHG, 8'hB2, "R8 flag kept over clear");
        // R6 several pins at once, falling
        pins = 7'h70; strobe(); strobe();
        rd(A_CHG, 8'h0B, "R6 multiple falls");
        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule